// File: doc/BRIEF.md
# Paired-Channel PWM Generator

This block drives eight pulse-width-modulated outputs arranged as four channel pairs. Each pair owns a 16-bit up-counter, a period value and three compare values. The even output of a pair marks the start of the cycle. The odd output marks a window between two compare points. All pair counters step on one shared tick. The tick comes from a power-of-two divider of the system clock, selectable from /2 to /256.

A falling edge on the external sync pin can restart every counter at once. Per-pair wrap flags feed one interrupt line, and software clears the flags by writing ones. Pairs 0 and 1 can run as an H-bridge. In that mode the high-side outputs (0 and 2) can be shut off. The four bridge outputs can also be gated by one enable or inverted together.

Software reaches the unit through a word-addressed write port and a registered read port. The control word is at address 0 and the wrap status is at address 1. Pair p uses addresses 4+4p (compare A), 5+4p (compare B), 6+4p (compare C) and 7+4p (period).

Top module: `pwm_pair_unit`

## Requirements
- R1: After reset the control word at address 0 reads 0x0012, the status word at address 1 and every pair register read 0, all eight outputs are low and the interrupt is low.
- R2: The counter tick fires once every 2^(d+1) clocks, where d is control bits [7:5]. A pair with period P therefore repeats every (P+1)*2^(d+1) clocks.
- R3: Output 2p is high while the count of pair p is below compare A. Output 2p+1 is high while the count is at least compare B and below compare C. As a result, compare A = 0 keeps output 2p low, and compare A above the period keeps it high.
- R4: When control bit 9 is set, a falling edge on `sync_in` restarts every pair counter and the divider, within four clocks. When bit 9 is clear, the pin is ignored.
- R5: Each counter runs from 0 to its period and then wraps to 0. Each wrap sets status bit p of the pair.
- R6: While running, a new period or compare value takes effect only when the pair wraps. While stopped, a new value takes effect at once.
- R7: Control bits [13:10] invert odd outputs 1, 3, 5 and 7 respectively.
- R8: Writing the status word clears exactly the bits written as one. A wrap in the same cycle wins over the clear.
- R9: The interrupt is high, one clock after the fact, exactly when control bit 8 is set and any status bit is pending.
- R10: While control bit 0 (run) is clear, all counters are held at zero and all outputs are low.
- R11: With bridge mode (bit 2) and high-side-off (bit 1) both set, outputs 0 and 2 stay low.
- R12: With bridge mode set and high-side-off clear, control bit 4 clear forces outputs 0 to 3 low. Bit 4 set lets them run.
- R13: With bridge mode set, control bit 3 inverts outputs 0 to 3. The high-side shutoff and the enable gating still force them low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address for write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Data of the word addressed one clock earlier |
| sync_in | input | 1 | Asynchronous sync pin, idle high, acts on its falling edge |
| pwm_out | output | 8 | PWM outputs, pair p on bits 2p and 2p+1 |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties watch several rules on every clock:
- the divider never fires two ticks in a row;
- a count never passes the active period;
- a wrap or an armed sync leaves the counter at zero;
- a status clear really drops the written bits;
- the interrupt stays low while it is disabled;
- a stopped unit keeps its outputs low;
- the high-side outputs stay low under shutoff.

Duty ratios, the clock-divided period and odd-output inversion only show over whole PWM cycles, so the bench measures high-time and edge counts in scenarios. The same applies to deferred loading of a new compare value at the wrap, restart timing after a sync edge, and the bridge gating and polarity combinations.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  parameter int NUM_PAIRS = 4;
  parameter int HB_PAIRS  = 2;
  parameter int DIV_BITS  = 3;

  // control word, LSB first: run, hs_off, hb_mode, hb_pol, hb_en, div, irq_en, sync_en, odd_inv
  typedef struct packed {
    logic [1:0]           spare;
    logic [NUM_PAIRS-1:0] odd_inv;
    logic                 sync_en;
    logic                 irq_en;
    logic [DIV_BITS-1:0]  div;
    logic                 hb_en;
    logic                 hb_pol;
    logic                 hb_mode;
    logic                 hs_off;
    logic                 run;
  } ctrl_t;

  localparam logic [15:0] CTRL_RESET = 16'h0012;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
  localparam int PAIR_GRP  = 1;  // pair p occupies word group PAIR_GRP + p
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NPAIR = NUM_PAIRS,
  parameter int DW    = 16,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [NPAIR-1:0] wrap,
  output ctrl_t            ctrl,
  output logic [DW-1:0]    cmp_a [NPAIR],
  output logic [DW-1:0]    cmp_b [NPAIR],
  output logic [DW-1:0]    cmp_c [NPAIR],
  output logic [DW-1:0]    per   [NPAIR],
  output logic [NPAIR-1:0] pend,
  output logic             irq,
  output logic [DW-1:0]    rdata
);
  localparam int PIW = (NPAIR > 1) ? $clog2(NPAIR) : 1;

  logic [AW-3:0]    grp;
  logic             is_pair;
  logic [PIW-1:0]   pidx;
  logic [NPAIR-1:0] clr_mask;
  logic [DW-1:0]    rd_next;

  assign grp     = addr[AW-1:2];
  assign is_pair = (int'(grp) >= PAIR_GRP) && (int'(grp) < PAIR_GRP + NPAIR);
  assign pidx    = PIW'(int'(grp) - PAIR_GRP);

  always_ff @(posedge clk) begin
    if (rst) ctrl <= ctrl_t'(CTRL_RESET);
    else if (we && int'(addr) == ADDR_CTRL) ctrl <= ctrl_t'(wdata);
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NPAIR; p++) begin
      if (rst) begin
        cmp_a[p] <= '0;
        cmp_b[p] <= '0;
        cmp_c[p] <= '0;
        per[p]   <= '0;
      end else if (we && int'(grp) == PAIR_GRP + p) begin
        case (addr[1:0])
          2'd0: cmp_a[p] <= wdata;
          2'd1: cmp_b[p] <= wdata;
          2'd2: cmp_c[p] <= wdata;
          default: per[p] <= wdata;
        endcase
      end
    end
  end

  assign clr_mask = (we && int'(addr) == ADDR_STAT) ? wdata[NPAIR-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= (pend & ~clr_mask) | wrap;
      irq  <= ctrl.irq_en & (|pend);
    end
  end

  always_comb begin
    rd_next = '0;
    if (int'(addr) == ADDR_CTRL) rd_next = ctrl;
    else if (int'(addr) == ADDR_STAT) rd_next = DW'(pend);
    else if (is_pair) begin
      case (addr[1:0])
        2'd0: rd_next = cmp_a[pidx];
        2'd1: rd_next = cmp_b[pidx];
        2'd2: rd_next = cmp_c[pidx];
        default: rd_next = per[pidx];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else rdata <= rd_next;
  end

  // R8
  w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (we && int'(addr) == ADDR_STAT && wrap == '0) |=> ((pend & $past(wdata[NPAIR-1:0])) == '0));
  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl.irq_en |=> !irq);
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
#(
  parameter int DB = DIV_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          clr,
  input  logic [DB-1:0] div,
  output logic          tick
);
  localparam int CW = 2 ** DB;

  logic [CW:0]   span;
  logic [CW-1:0] lim;
  logic [CW-1:0] cnt;

  always_comb begin
    span = (CW + 1)'(1) << (int'(div) + 1);
    lim  = CW'(span - (CW + 1)'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || !run || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + CW'(1);
      tick <= 1'b0;
    end
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          clr,
  input  logic          tick,
  input  logic [DW-1:0] cmp_a,
  input  logic [DW-1:0] cmp_b,
  input  logic [DW-1:0] cmp_c,
  input  logic [DW-1:0] per,
  output logic          lead,
  output logic          win,
  output logic          wrap
);
  logic [DW-1:0] cnt, sh_a, sh_b, sh_c, sh_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sh_a <= '0;
      sh_b <= '0;
      sh_c <= '0;
      sh_p <= '0;
      wrap <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (!run) begin
        cnt  <= '0;
        sh_a <= cmp_a;
        sh_b <= cmp_b;
        sh_c <= cmp_c;
        sh_p <= per;
      end else if (clr) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt >= sh_p) begin
          cnt  <= '0;
          wrap <= 1'b1;
          sh_a <= cmp_a;
          sh_b <= cmp_b;
          sh_c <= cmp_c;
          sh_p <= per;
        end else begin
          cnt <= cnt + DW'(1);
        end
      end
    end
  end

  assign lead = cnt < sh_a;
  assign win  = (cnt >= sh_b) && (cnt < sh_c);

  // R5
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= sh_p);
  // R5
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |-> cnt == '0);
  // R4
  sync_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (run && clr) |=> cnt == '0);
endmodule

// File: rtl/pwm_pair_unit.sv
module pwm_pair_unit
  import pwm_pkg::*;
#(
  parameter int NPAIR = NUM_PAIRS,
  parameter int NHB   = HB_PAIRS,
  parameter int DW    = 16,
  parameter int AW    = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  input  logic               sync_in,
  output logic [2*NPAIR-1:0] pwm_out,
  output logic               irq
);
  localparam int NOUT   = 2 * NPAIR;
  localparam int HB_OUT = 2 * NHB;

  ctrl_t            ctrl;
  logic [DW-1:0]    cmp_a [NPAIR];
  logic [DW-1:0]    cmp_b [NPAIR];
  logic [DW-1:0]    cmp_c [NPAIR];
  logic [DW-1:0]    per   [NPAIR];
  logic [NPAIR-1:0] wrap, pend;
  logic             tick, sync_clr;
  logic             s_meta, s_sync, s_prev;
  logic [NOUT-1:0]  raw, shaped;

  pwm_regs #(.NPAIR(NPAIR), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .wrap(wrap), .ctrl(ctrl), .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c),
    .per(per), .pend(pend), .irq(irq), .rdata(reg_rdata)
  );

  // two-flop synchroniser, then falling-edge detect
  always_ff @(posedge clk) begin
    if (rst) begin
      s_meta <= 1'b1;
      s_sync <= 1'b1;
      s_prev <= 1'b1;
    end else begin
      s_meta <= sync_in;
      s_sync <= s_meta;
      s_prev <= s_sync;
    end
  end
  assign sync_clr = ctrl.sync_en & s_prev & ~s_sync;

  pwm_prescaler #(.DB(DIV_BITS)) u_div (
    .clk(clk), .rst(rst), .run(ctrl.run), .clr(sync_clr), .div(ctrl.div), .tick(tick)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic lead, win;
    pwm_pair #(.DW(DW)) u_pair (
      .clk(clk), .rst(rst), .run(ctrl.run), .clr(sync_clr), .tick(tick),
      .cmp_a(cmp_a[p]), .cmp_b(cmp_b[p]), .cmp_c(cmp_c[p]), .per(per[p]),
      .lead(lead), .win(win), .wrap(wrap[p])
    );
    assign raw[2*p]   = lead;
    assign raw[2*p+1] = win ^ ctrl.odd_inv[p];
  end

  always_comb begin
    shaped = raw;
    if (ctrl.hb_mode) begin
      if (ctrl.hb_pol) shaped[HB_OUT-1:0] = ~raw[HB_OUT-1:0];
      if (ctrl.hs_off) begin
        for (int h = 0; h < NHB; h++) shaped[2*h] = 1'b0;
      end else if (!ctrl.hb_en) begin
        shaped[HB_OUT-1:0] = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !ctrl.run) pwm_out <= '0;
    else pwm_out <= shaped;
  end

  // R10
  stopped_low_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl.run |=> pwm_out == '0);

  for (genvar h = 0; h < NHB; h++) begin : g_hs_chk
    // R11
    high_side_off_chk: assert property (@(posedge clk) disable iff (rst)
      (ctrl.hb_mode && ctrl.hs_off) |=> !pwm_out[2*h]);
  end
endmodule

// File: tb/tb_pwm_pair_unit.sv
`timescale 1ns/1ps
module tb_pwm_pair_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        sync_in = 1'b1;
  logic [7:0]  pwm_out;
  logic        irq;

  always #2 clk = ~clk;  // 250 MHz

  pwm_pair_unit dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sync_in(sync_in),
    .pwm_out(pwm_out), .irq(irq)
  );

  typedef struct { string req; int exp; } exp_t;
  exp_t exp_q[$];
  int   obs_q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;
  exp_t e;
  int   o;

  // monitor: pairs each expected item with the next observation
  always @(negedge clk) begin
    while (exp_q.size() > 0 && obs_q.size() > 0) begin
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      checks++;
      if (o != e.exp) begin
        failures++;
        $display("FAIL %s: actual=%0d expected=%0d", e.req, o, e.exp);
      end
    end
  end

  task automatic chk(input string req, input int exp, input int act);
    exp_q.push_back('{req, exp});
    obs_q.push_back(act);
  endtask

  function automatic logic [15:0] mk(input bit run, input bit hs_off, input bit hb_mode,
                                     input bit hb_pol, input bit hb_en, input int div,
                                     input bit irq_en, input bit sync_en, input int inv);
    return 16'(run) | (16'(hs_off) << 1) | (16'(hb_mode) << 2) | (16'(hb_pol) << 3) |
           (16'(hb_en) << 4) | (16'(div & 7) << 5) | (16'(irq_en) << 8) |
           (16'(sync_en) << 9) | (16'(inv & 15) << 10);
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = 5'(a);
    @(negedge clk);
    d = int'(reg_rdata);
  endtask

  task automatic cfg_pair(input int p, input int c0, input int c1, input int c2, input int pr);
    wr(4 + 4*p, c0); wr(5 + 4*p, c1); wr(6 + 4*p, c2); wr(7 + 4*p, pr);
  endtask

  task automatic cfg_all(input int c0, input int c1, input int c2, input int pr);
    for (int p = 0; p < 4; p++) cfg_pair(p, c0, c1, c2, pr);
  endtask

  task automatic measure(input int idx, input int n, output int hi, output int rises);
    logic prev;
    hi = 0; rises = 0;
    @(negedge clk);
    prev = pwm_out[idx];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[idx]) hi++;
      if (pwm_out[idx] && !prev) rises++;
      prev = pwm_out[idx];
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v, hi, r, h1, h2;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 outputs", 0, int'(pwm_out));
    chk("R1 irq", 0, int'(irq));
    rd(0, v); chk("R1 ctrl", 'h12, v);
    rd(1, v); chk("R1 status", 0, v);
    rd(9, v); chk("R1 pair reg", 0, v);

    // R3 base waveform, /2 divider, period 9
    cfg_all(3, 2, 5, 9);
    wr(0, mk(1,0,0,0,0,0,0,0,0));
    wait_cycles(40);
    measure(0, 100, hi, r); chk("R3 even duty", 30, hi);
    measure(1, 100, hi, r); chk("R3 odd window", 30, hi);
    measure(6, 100, hi, r); chk("R3 pair3 even", 30, hi);

    // R7 invert output 7 only (bit 13)
    wr(0, mk(1,0,0,0,0,0,0,0,8));
    wait_cycles(4);
    measure(7, 100, hi, r); chk("R7 out7 inverted", 70, hi);
    measure(1, 100, hi, r); chk("R7 out1 untouched", 30, hi);

    // R3 compare boundaries, R6 applied at wrap while running
    wr(4 + 4*1, 0);
    wr(4 + 4*2, 12);
    wait_cycles(40);
    measure(2, 100, hi, r); chk("R3 compare zero", 0, hi);
    measure(4, 100, hi, r); chk("R3 compare above period", 100, hi);

    // R2 /16 divider
    wr(0, mk(0,0,0,0,0,0,0,0,0));
    cfg_all(3, 2, 5, 9);
    wr(0, mk(1,0,0,0,0,3,0,0,0));
    wait_cycles(200);
    measure(0, 320, hi, r);
    chk("R2 high time /16", 96, hi);
    chk("R2 cycle count /16", 2, r);

    // R6 shadowed compare
    wr(0, mk(1,0,0,0,0,0,0,0,0));
    wait_cycles(40);
    @(negedge clk);
    while (!pwm_out[0]) @(negedge clk);
    h1 = 1; h2 = 0;
    fork
      begin
        for (int i = 1; i < 40; i++) begin
          @(negedge clk);
          if (pwm_out[0]) begin
            if (i < 20) h1++; else h2++;
          end
        end
      end
      begin
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'd4; reg_wdata = 16'd8;
        @(negedge clk);
        reg_we = 1'b0;
      end
    join
    chk("R6 old compare kept", 6, h1);
    chk("R6 new compare at wrap", 16, h2);

    // R4 sync restart
    wr(0, mk(0,0,0,0,0,0,0,1,0));
    cfg_all(1, 0, 0, 99);
    wr(0, mk(1,0,0,0,0,0,0,1,0));
    @(negedge clk);
    while (!pwm_out[0]) @(negedge clk);
    while (pwm_out[0]) @(negedge clk);
    wait_cycles(50);
    sync_in = 1'b0;
    measure(0, 12, hi, r);
    sync_in = 1'b1;
    chk("R4 restart on falling edge", 1, int'(hi > 0));
    wr(0, mk(1,0,0,0,0,0,0,0,0));
    @(negedge clk);
    while (!pwm_out[0]) @(negedge clk);
    while (pwm_out[0]) @(negedge clk);
    wait_cycles(50);
    sync_in = 1'b0;
    measure(0, 12, hi, r);
    sync_in = 1'b1;
    chk("R4 ignored when disabled", 0, hi);

    // R5 R8 R9 wrap flags and interrupt
    wr(0, mk(0,0,0,0,0,0,1,0,0));
    cfg_all(3, 2, 5, 9);
    wr(0, mk(1,0,0,0,0,0,1,0,0));
    wait_cycles(40);
    chk("R9 irq raised", 1, int'(irq));
    wr(0, mk(0,0,0,0,0,0,1,0,0));
    wait_cycles(4);
    chk("R10 stopped outputs low", 0, int'(pwm_out));
    rd(1, v); chk("R5 all pairs wrapped", 'hF, v);
    wr(1, 'h5);
    rd(1, v); chk("R8 partial clear", 'hA, v);
    chk("R9 irq still pending", 1, int'(irq));
    wr(1, 'hA);
    @(negedge clk);
    chk("R9 irq dropped", 0, int'(irq));
    rd(1, v); chk("R8 all cleared", 0, v);
    wr(0, mk(1,0,0,0,0,0,0,0,0));
    wait_cycles(40);
    wr(0, mk(0,0,0,0,0,0,0,0,0));
    wait_cycles(4);
    rd(1, v); chk("R5 flags without enable", 'hF, v);
    chk("R9 irq masked", 0, int'(irq));
    wr(1, 'hF);

    // R11 R12 R13 H-bridge
    wr(0, mk(1,1,1,0,1,0,0,0,0));
    wait_cycles(40);
    measure(0, 100, hi, r); chk("R11 out0 off", 0, hi);
    measure(2, 100, hi, r); chk("R11 out2 off", 0, hi);
    measure(1, 100, hi, r); chk("R11 low side runs", 30, hi);
    wr(0, mk(1,0,1,0,0,0,0,0,0));
    wait_cycles(4);
    measure(1, 100, hi, r); chk("R12 bridge disabled", 0, hi);
    measure(4, 100, hi, r); chk("R12 other pairs run", 30, hi);
    wr(0, mk(1,0,1,0,1,0,0,0,0));
    wait_cycles(4);
    measure(3, 100, hi, r); chk("R12 bridge enabled", 30, hi);
    wr(0, mk(1,0,1,1,1,0,0,0,0));
    wait_cycles(4);
    measure(0, 100, hi, r); chk("R13 out0 inverted", 70, hi);
    measure(1, 100, hi, r); chk("R13 out1 inverted", 70, hi);
    measure(4, 100, hi, r); chk("R13 pair2 untouched", 30, hi);
    wr(0, mk(1,1,1,1,1,0,0,0,0));
    wait_cycles(4);
    measure(0, 100, hi, r); chk("R13 shutoff wins over polarity", 0, hi);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule